// File: doc/BRIEF.md
# Memory Controller Operating-State Machine

This block tracks the operating state of a DRAM protocol controller. Software or a local sequencer writes a 3-bit state command. The block moves between the stable states init, config, access and low-power. Every move passes through a request state, and the request state is held until the memory side returns an acknowledge. The block also records what put the controller into low-power, either a software sleep or a hardware idle request, and reports that trigger next to the 3-bit status.

Two helper inputs, goto_cfg and goto_acc, start a built-in sequencer. The sequencer issues the commands needed to reach config or access from whatever stable state the block is in. A controller leaving low-power always goes to access first, never straight to config.

Status codes: init=0, config=1, config-request=2, access=3, access-request=4, low-power=5, low-power-entry-request=6, low-power-exit-request=7. Command codes: init=0, config=1, go=2, sleep=3, wakeup=4. Codes 5 to 7 are not commands. The trigger field reads 1 for hardware-triggered low-power, 2 for software-triggered low-power, and 0 outside the low-power states.

Top module: `mc_opstate_fsm`

## Requirements
- R1: While reset is held and just after it is released, the status is init (0), the trigger field is 0 and busy_o is low.
- R2: A request state (2, 4, 6 or 7) holds until mem_ack is sampled high at a clock edge. Its target state then appears on the next edge: 2 resolves to config (1), 4 to access (3), 6 to low-power (5) and 7 to access (3). mem_ack has no effect in a stable state.
- R3: A config command (1) in init or in access moves the status to config-request (2) on the next edge.
- R4: A go command (2) in config moves the status to access-request (4) on the next edge.
- R5: A sleep command (3) in access moves the status to entry-request (6) and sets the trigger to 2. With no command valid, the helper idle and lp_req high in access, the status moves to 6 with the trigger set to 1.
- R6: A wakeup command (4) in low-power moves the status to exit-request (7). When the trigger is 1 and lp_req is low, low-power also moves to 7 with no command. Resolving 7 clears the trigger to 0. A config command in low-power is ignored.
- R7: Any command not listed in R3 to R6 leaves the status unchanged. This covers the init command, codes 5 to 7, any command given in a request state, and a command for the state already current (config in config, go in access, sleep in low-power).
- R8: A goto_cfg pulse with the helper idle raises busy_o on the next edge. The helper then issues wakeup, config or nothing, as the current state requires, until config is reached. busy_o drops one edge after config is seen. cmd_valid is ignored while busy_o is high.
- R9: A goto_acc pulse, when goto_cfg is low, does the same toward access: config from init, go from config, wakeup from low-power. The pulse is ignored, and busy_o stays low, when the block is in low-power with trigger 1.
- R10: status_o[6:4] carries the trigger, status_o[3] is 0, and the trigger is 0 in every state other than 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | State command present this cycle |
| cmd | input | 3 | State command code |
| mem_ack | input | 1 | Memory-side handshake completing the current request state |
| lp_req | input | 1 | Hardware idle request for low-power entry; its fall ends hardware low-power |
| goto_cfg | input | 1 | Start the helper toward config |
| goto_acc | input | 1 | Start the helper toward access |
| status_o | output | 7 | [2:0] state, [3] zero, [6:4] low-power trigger |
| busy_o | output | 1 | Helper sequence in progress |

## Verification
Every result of this block is registered once. A command, acknowledge or helper pulse sampled at one edge is visible on status_o or busy_o right after that same edge. A helper command appears one edge after busy_o rises, because the helper issues its commands from its registered goal. The bench drives inputs on the falling edge, advances a reference model by one step, and compares the outputs one time unit after the rising edge, so every result is checked in the cycle it is due. Directed sequences cover the named transitions, and a seeded random run mixes commands, acknowledges, idle requests and helper pulses.

// File: rtl/mc_opstate_pkg.sv
package mc_opstate_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_CONFIG  = 3'd1,
        ST_CFG_REQ = 3'd2,
        ST_ACCESS  = 3'd3,
        ST_ACC_REQ = 3'd4,
        ST_LOWPWR  = 3'd5,
        ST_LPE_REQ = 3'd6,
        ST_LPX_REQ = 3'd7
    } op_state_e;

    localparam logic [2:0] CMD_INIT  = 3'd0;
    localparam logic [2:0] CMD_CFG   = 3'd1;
    localparam logic [2:0] CMD_GO    = 3'd2;
    localparam logic [2:0] CMD_SLEEP = 3'd3;
    localparam logic [2:0] CMD_WAKE  = 3'd4;

    typedef enum logic [1:0] {
        GOAL_NONE = 2'd0,
        GOAL_CFG  = 2'd1,
        GOAL_ACC  = 2'd2
    } goal_e;

endpackage

// File: rtl/mc_seq_helper.sv
module mc_seq_helper
    import mc_opstate_pkg::*;
#(
    parameter int          TRIG_W  = 3,
    parameter logic [TRIG_W-1:0] HW_TRIG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              goto_cfg,
    input  logic              goto_acc,
    input  op_state_e         state,
    input  logic [TRIG_W-1:0] trig,
    output logic              busy,
    output logic              hcmd_valid,
    output logic [2:0]        hcmd
);

    goal_e goal_q, goal_d;
    logic  hw_locked;

    assign hw_locked = (state == ST_LOWPWR) && (trig == HW_TRIG);

    // goal register
    always_comb begin
        goal_d = goal_q;
        unique case (goal_q)
            GOAL_NONE: begin
                if (goto_cfg)
                    goal_d = GOAL_CFG;
                else if (goto_acc && !hw_locked)
                    goal_d = GOAL_ACC;
            end
            GOAL_CFG: if (state == ST_CONFIG) goal_d = GOAL_NONE;
            GOAL_ACC: if (state == ST_ACCESS) goal_d = GOAL_NONE;
            default:  goal_d = GOAL_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) goal_q <= GOAL_NONE;
        else        goal_q <= goal_d;
    end

    // command issue from the registered goal
    always_comb begin
        hcmd_valid = 1'b0;
        hcmd       = CMD_INIT;
        unique case (goal_q)
            GOAL_CFG: begin
                if (state == ST_LOWPWR) begin
                    hcmd_valid = 1'b1; hcmd = CMD_WAKE;
                end else if (state == ST_INIT || state == ST_ACCESS) begin
                    hcmd_valid = 1'b1; hcmd = CMD_CFG;
                end
            end
            GOAL_ACC: begin
                if (state == ST_LOWPWR) begin
                    hcmd_valid = 1'b1; hcmd = CMD_WAKE;
                end else if (state == ST_INIT) begin
                    hcmd_valid = 1'b1; hcmd = CMD_CFG;
                end else if (state == ST_CONFIG) begin
                    hcmd_valid = 1'b1; hcmd = CMD_GO;
                end
            end
            default: ;
        endcase
    end

    assign busy = (goal_q != GOAL_NONE);

endmodule

// File: rtl/mc_cmd_select.sv
module mc_cmd_select
    import mc_opstate_pkg::*;
#(
    parameter int          TRIG_W  = 3,
    parameter logic [TRIG_W-1:0] HW_TRIG = 1
) (
    input  logic              busy,
    input  logic              hcmd_valid,
    input  logic [2:0]        hcmd,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic              lp_req,
    input  op_state_e         state,
    input  logic [TRIG_W-1:0] trig,
    output logic              eff_valid,
    output logic [2:0]        eff_cmd,
    output logic              hw_enter,
    output logic              hw_exit
);

    always_comb begin
        if (busy) begin
            eff_valid = hcmd_valid;
            eff_cmd   = hcmd;
        end else begin
            eff_valid = cmd_valid;
            eff_cmd   = cmd;
        end
        hw_enter = !busy && !cmd_valid && lp_req && (state == ST_ACCESS);
        hw_exit  = (state == ST_LOWPWR) && (trig == HW_TRIG) && !lp_req;
    end

endmodule

// File: rtl/mc_state_core.sv
module mc_state_core
    import mc_opstate_pkg::*;
#(
    parameter int          TRIG_W  = 3,
    parameter logic [TRIG_W-1:0] HW_TRIG = 1,
    parameter logic [TRIG_W-1:0] SW_TRIG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eff_valid,
    input  logic [2:0]        eff_cmd,
    input  logic              hw_enter,
    input  logic              hw_exit,
    input  logic              mem_ack,
    output op_state_e         state_o,
    output logic [TRIG_W-1:0] trig_o
);

    op_state_e         st_q, st_d;
    logic [TRIG_W-1:0] trig_q, trig_d;
    logic              is_cfg, is_go, is_sleep, is_wake;

    assign is_cfg   = eff_valid && (eff_cmd == CMD_CFG);
    assign is_go    = eff_valid && (eff_cmd == CMD_GO);
    assign is_sleep = eff_valid && (eff_cmd == CMD_SLEEP);
    assign is_wake  = eff_valid && (eff_cmd == CMD_WAKE);

    always_comb begin
        st_d   = st_q;
        trig_d = trig_q;
        unique case (st_q)
            ST_INIT:    if (is_cfg) st_d = ST_CFG_REQ;
            ST_CONFIG:  if (is_go)  st_d = ST_ACC_REQ;
            ST_ACCESS: begin
                if (is_cfg) begin
                    st_d = ST_CFG_REQ;
                end else if (is_sleep) begin
                    st_d   = ST_LPE_REQ;
                    trig_d = SW_TRIG;
                end else if (hw_enter) begin
                    st_d   = ST_LPE_REQ;
                    trig_d = HW_TRIG;
                end
            end
            ST_LOWPWR:  if (is_wake || hw_exit) st_d = ST_LPX_REQ;
            ST_CFG_REQ: if (mem_ack) st_d = ST_CONFIG;
            ST_ACC_REQ: if (mem_ack) st_d = ST_ACCESS;
            ST_LPE_REQ: if (mem_ack) st_d = ST_LOWPWR;
            ST_LPX_REQ: begin
                if (mem_ack) begin
                    st_d   = ST_ACCESS;
                    trig_d = '0;
                end
            end
            default:    st_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_INIT;
            trig_q <= '0;
        end else begin
            st_q   <= st_d;
            trig_q <= trig_d;
        end
    end

    assign state_o = st_q;
    assign trig_o  = trig_q;

endmodule

// File: rtl/mc_opstate_fsm.sv
module mc_opstate_fsm
    import mc_opstate_pkg::*;
#(
    parameter int TRIG_W = 3,
    localparam int STAT_W = TRIG_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic              mem_ack,
    input  logic              lp_req,
    input  logic              goto_cfg,
    input  logic              goto_acc,
    output logic [STAT_W-1:0] status_o,
    output logic              busy_o
);

    localparam logic [TRIG_W-1:0] HW_TRIG = TRIG_W'(1);
    localparam logic [TRIG_W-1:0] SW_TRIG = TRIG_W'(2);

    op_state_e         state;
    logic [TRIG_W-1:0] trig;
    logic              busy, hcmd_valid, eff_valid, hw_enter, hw_exit;
    logic [2:0]        hcmd, eff_cmd;

    mc_seq_helper #(.TRIG_W(TRIG_W), .HW_TRIG(HW_TRIG)) u_helper (
        .clk(clk), .rst_n(rst_n), .goto_cfg(goto_cfg), .goto_acc(goto_acc),
        .state(state), .trig(trig), .busy(busy),
        .hcmd_valid(hcmd_valid), .hcmd(hcmd)
    );

    mc_cmd_select #(.TRIG_W(TRIG_W), .HW_TRIG(HW_TRIG)) u_select (
        .busy(busy), .hcmd_valid(hcmd_valid), .hcmd(hcmd),
        .cmd_valid(cmd_valid), .cmd(cmd), .lp_req(lp_req),
        .state(state), .trig(trig), .eff_valid(eff_valid),
        .eff_cmd(eff_cmd), .hw_enter(hw_enter), .hw_exit(hw_exit)
    );

    mc_state_core #(.TRIG_W(TRIG_W), .HW_TRIG(HW_TRIG), .SW_TRIG(SW_TRIG)) u_core (
        .clk(clk), .rst_n(rst_n), .eff_valid(eff_valid), .eff_cmd(eff_cmd),
        .hw_enter(hw_enter), .hw_exit(hw_exit), .mem_ack(mem_ack),
        .state_o(state), .trig_o(trig)
    );

    assign status_o = {trig, 1'b0, state};
    assign busy_o   = busy;

endmodule

// File: rtl/mc_opstate_fsm_chk.sv
module mc_opstate_fsm_chk #(
    parameter int TRIG_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd,
    input logic              mem_ack,
    input logic              goto_cfg,
    input logic              goto_acc,
    input logic [TRIG_W+3:0] status_o,
    input logic              busy_o
);

    logic [2:0]        st;
    logic [TRIG_W-1:0] tr;
    assign st = status_o[2:0];
    assign tr = status_o[TRIG_W+3:4];

    AST_CFGREQ_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd2 && mem_ack) |=> (st == 3'd1));                       // R2
    AST_EXIT_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd7 && mem_ack) |=> (st == 3'd3 && tr == '0));           // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd6 && !mem_ack) |=> (st == 3'd6));                      // R2
    AST_CONFIG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && $past(st) != 3'd1 && $past(rst_n)) |-> ($past(st) == 3'd2)); // R3
    AST_SAME_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && !busy_o && cmd_valid && cmd == 3'd1) |=> (st == 3'd1)); // R7
    AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && st == 3'd5 && tr == TRIG_W'(1) && goto_acc && !goto_cfg) |=> !busy_o); // R9
    AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st < 3'd5) |-> (tr == '0 && status_o[3] == 1'b0));              // R10

endmodule

bind mc_opstate_fsm mc_opstate_fsm_chk #(.TRIG_W(TRIG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .mem_ack(mem_ack), .goto_cfg(goto_cfg), .goto_acc(goto_acc),
    .status_o(status_o), .busy_o(busy_o)
);

// File: tb/mc_opstate_fsm_bench.sv
module mc_opstate_fsm_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       mem_ack = 1'b0;
    logic       lp_req = 1'b0;
    logic       goto_cfg = 1'b0;
    logic       goto_acc = 1'b0;
    logic [6:0] status_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [2:0] m_st = 3'd0;
    logic [2:0] m_tr = 3'd0;
    int         m_goal = 0;   // 0 none, 1 config, 2 access

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_opstate_fsm u_mc_opstate_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .mem_ack(mem_ack), .lp_req(lp_req), .goto_cfg(goto_cfg),
        .goto_acc(goto_acc), .status_o(status_o), .busy_o(busy_o)
    );

    function automatic logic [3:0] helper_cmd(int goal, logic [2:0] s);
        // returns {valid, cmd}
        if (goal == 1) begin
            if (s == 3'd5) return {1'b1, 3'd4};
            if (s == 3'd0 || s == 3'd3) return {1'b1, 3'd1};
        end else if (goal == 2) begin
            if (s == 3'd5) return {1'b1, 3'd4};
            if (s == 3'd0) return {1'b1, 3'd1};
            if (s == 3'd1) return {1'b1, 3'd2};
        end
        return 4'd0;
    endfunction

    task automatic model_step();
        logic       ev;
        logic [2:0] ec;
        logic [3:0] h;
        logic [2:0] ns, nt;
        int         ng;
        logic       hen, hex;
        h  = helper_cmd(m_goal, m_st);
        ev = (m_goal != 0) ? h[3] : cmd_valid;
        ec = (m_goal != 0) ? h[2:0] : cmd;
        hen = (m_goal == 0) && !cmd_valid && lp_req && m_st == 3'd3;
        hex = (m_st == 3'd5) && (m_tr == 3'd1) && !lp_req;
        ns = m_st; nt = m_tr;
        case (m_st)
            3'd0: if (ev && ec == 3'd1) ns = 3'd2;
            3'd1: if (ev && ec == 3'd2) ns = 3'd4;
            3'd3: begin
                if (ev && ec == 3'd1) ns = 3'd2;
                else if (ev && ec == 3'd3) begin ns = 3'd6; nt = 3'd2; end
                else if (hen) begin ns = 3'd6; nt = 3'd1; end
            end
            3'd5: if ((ev && ec == 3'd4) || hex) ns = 3'd7;
            3'd2: if (mem_ack) ns = 3'd1;
            3'd4: if (mem_ack) ns = 3'd3;
            3'd6: if (mem_ack) ns = 3'd5;
            default: if (mem_ack) begin ns = 3'd3; nt = 3'd0; end
        endcase
        ng = m_goal;
        if (m_goal == 0) begin
            if (goto_cfg) ng = 1;
            else if (goto_acc && !(m_st == 3'd5 && m_tr == 3'd1)) ng = 2;
        end else if (m_goal == 1 && m_st == 3'd1) ng = 0;
        else if (m_goal == 2 && m_st == 3'd3) ng = 0;
        m_st = ns; m_tr = nt; m_goal = ng;
    endtask

    task automatic compare(string tag);
        logic [6:0] exp_s;
        logic       exp_b;
        exp_s = {m_tr, 1'b0, m_st};
        exp_b = (m_goal != 0);
        checks++;
        if (status_o !== exp_s || busy_o !== exp_b) begin
            errors++;
            $display("FAIL %s: status=%h busy=%b expected status=%h busy=%b",
                     tag, status_o, busy_o, exp_s, exp_b);
        end
    endtask

    task automatic step(input logic cv, input logic [2:0] c, input logic a,
                        input logic lr, input logic gc, input logic ga, input string tag);
        @(negedge clk);
        cmd_valid = cv; cmd = c; mem_ack = a; lp_req = lr;
        goto_cfg = gc; goto_acc = ga;
        model_step();
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C3A));
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R1");
        // init -> config, request held without ack
        step(1, 3'd1, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd2, 0, 0, 0, 0, "R7");   // command in request state ignored
        step(0, 0, 1, 0, 0, 0, "R2");
        step(1, 3'd1, 0, 0, 0, 0, "R7");   // config in config: no-op
        step(1, 3'd0, 0, 0, 0, 0, "R7");   // init command ignored
        step(1, 3'd6, 1, 0, 0, 0, "R7");   // illegal code, stray ack
        step(1, 3'd2, 0, 0, 0, 0, "R4");
        step(0, 0, 1, 0, 0, 0, "R4");
        step(1, 3'd2, 0, 0, 0, 0, "R7");   // go in access: no-op
        // software sleep
        step(1, 3'd3, 0, 1, 0, 0, "R5");
        step(0, 0, 1, 0, 0, 0, "R10");
        step(1, 3'd1, 0, 0, 0, 0, "R6");   // config in low-power ignored
        step(1, 3'd4, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 0, 0, "R6");
        // hardware entry, helper to access locked out, hardware exit
        step(0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 1, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 1, "R9");
        step(0, 0, 0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 0, 0, "R6");
        // software sleep then helper to config
        step(1, 3'd3, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 0, "R8");
        for (int i = 0; i < 8; i++) step(1, 3'd3, 1, 0, 0, 0, "R8");
        // helper to access from config
        step(0, 0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, "R9");
        // seeded random mix
        for (int i = 0; i < 4000; i++) begin
            logic       rcv, ra, rl, rgc, rga;
            logic [2:0] rc;
            rcv = ($urandom % 10) < 4;
            rc  = 3'($urandom % 6);
            ra  = ($urandom % 10) < 3;
            rl  = ($urandom % 10) < 3;
            rgc = ($urandom % 100) < 3;
            rga = ($urandom % 100) < 3;
            step(rcv, rc, ra, rl, rgc, rga, "R2");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule